// File: doc/BRIEF.md
# Interleaved Memory Window Router

This block sits behind one fixed host memory window and spreads the accesses that land in it over a small set of downstream host-bridge ports. Its configuration is a window base, a window size, a target count and an optional granularity code. These are written together in one configuration strobe and checked as they are loaded. An accepted request carries a window-relative offset. The router adds the base to the offset to form the host physical address (HPA). It then picks a port by slicing the HPA at the interleave granularity and forwards the access there with the HPA unchanged. It returns the response from that port upstream.

An access that cannot be delivered never reaches a downstream port. This covers three cases: no window is active, the access runs past the window end, or the selected port has no device. Such a read completes with zero data and an error flag, which the host treats as poison. Such a write is dropped and completes with no error. The router keeps one request in flight.

Top module: `ilv_window_router`

## Requirements
- R1: A configuration strobe is accepted only when all three hold: the size is a nonzero multiple of 256 MiB, the target count is 1, 2, 4 or 8 (and no larger than the port count), and, when a granularity is supplied, its code is 0 to 6. Accepting sets `win_active` one cycle later. A rejected strobe clears `win_active` and pulses `cfg_rej` for one cycle.
- R2: When `cfg_gran_set` is 0 the granularity code is taken as 0 (256-byte interleave) and `cfg_gran` is ignored.
- R3: The forwarded address `dn_addr` equals window base plus request offset, modulo 2^ADDR_W.
- R4: The selected port index is (HPA / (256 << g)) mod target count, where g is the granularity code.
- R5: At most one bit of `dn_valid` is high at any time, and it stays high until the matching `dn_ready` bit is seen.
- R6: An unroutable read completes in the cycle after acceptance with `rsp_err`=1 and `rsp_rdata`=0, and no downstream valid is raised.
- R7: An unroutable write completes in the cycle after acceptance with `rsp_err`=0, and no downstream valid is raised.
- R8: A request is unroutable when any of these holds: no window is active, offset + (len+1) is greater than the window size, or the selected port's `tgt_present` bit is 0.
- R9: For a routed request, `rsp_err` and `rsp_rdata` equal the error bit and data that the selected port returns.
- R10: `req_ready` is high only when no request is in flight, so a second request waits until the previous response has been given.
- R11: `dn_we`, `dn_len` (byte count minus one, 0 to 7) and `dn_wdata` (little-endian byte lanes) are forwarded unchanged, with no alignment condition on the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load and check the configuration fields |
| cfg_base | input | ADDR_W | Window base address |
| cfg_size | input | ADDR_W | Window size in bytes |
| cfg_ways | input | 4 | Number of interleave targets |
| cfg_gran_set | input | 1 | A granularity code is supplied |
| cfg_gran | input | 3 | Granularity code g (256 << g bytes) |
| win_active | output | 1 | A legal configuration is loaded |
| cfg_rej | output | 1 | One-cycle pulse: the last strobe was rejected |
| tgt_present | input | NTGT | A device sits behind each port |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Router can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_off | input | ADDR_W | Window-relative byte offset |
| req_len | input | 3 | Byte count minus one |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Error / poison completion |
| rsp_rdata | output | DATA_W | Read data |
| dn_valid | output | NTGT | Per-port request valid |
| dn_ready | input | NTGT | Per-port request ready |
| dn_we | output | 1 | Forwarded write flag |
| dn_addr | output | ADDR_W | Forwarded HPA |
| dn_len | output | 3 | Forwarded byte count minus one |
| dn_wdata | output | DATA_W | Forwarded write data |
| dn_rsp_valid | input | NTGT | Per-port response strobe |
| dn_rsp_err | input | NTGT | Per-port response error |
| dn_rsp_rdata | input | NTGT*DATA_W | Per-port response data |

## Verification
The assertions assume three things about the ports. A downstream port answers only after it has taken the request, and only on the index that was selected. `req_valid` is raised only while `req_ready` is high, because acceptance is sampled there. The configuration is not rewritten while a request is in flight. The bench's responder model answers one cycle after it sees a handshake, and only on that port. The bench drives a request only from idle and waits for each response. It loads new configurations only between requests. Random offsets are drawn inside the window so that the range rule is exercised only by directed cases.

// File: rtl/iwr_pkg.sv
package iwr_pkg;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_ISSUE = 2'd1,
    XS_WAIT  = 2'd2,
    XS_RESP  = 2'd3
  } xact_st_t;

  // nonzero and a whole number of 2**lsb units
  function automatic logic size_is_legal(input logic [63:0] sz, input int lsb);
    return (sz != 64'd0) && ((sz & ((64'd1 << lsb) - 64'd1)) == 64'd0);
  endfunction

  // power of two and not above the port count
  function automatic logic ways_is_legal(input logic [3:0] n, input int max_n);
    return (n != 4'd0) && ((n & (n - 4'd1)) == 4'd0) && (int'(n) <= max_n);
  endfunction

  function automatic logic [2:0] ways_to_log2(input logic [3:0] n);
    logic [2:0] r;
    r = 3'd0;
    for (int b = 0; b < 4; b++) begin
      if (n[b]) r = 3'(b);
    end
    return r;
  endfunction

  // (hpa / (256 << g)) mod 2**wlog, as a shift and a mask
  function automatic logic [63:0] slice_target(input logic [63:0] hpa,
                                               input logic [2:0] g,
                                               input logic [2:0] wlog);
    return (hpa >> (8 + int'(g))) & ((64'd1 << wlog) - 64'd1);
  endfunction

endpackage

// File: rtl/iwr_cfg.sv
module iwr_cfg
  import iwr_pkg::*;
#(
  parameter int ADDR_W   = 52,
  parameter int NTGT     = 8,
  parameter int SIZE_LSB = 28,
  parameter int GRAN_MAX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_size,
  input  logic [3:0]        cfg_ways,
  input  logic              cfg_gran_set,
  input  logic [2:0]        cfg_gran,
  output logic              active,
  output logic              rej,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] size_q,
  output logic [2:0]        wlog_q,
  output logic [2:0]        gran_q
);

  logic       size_ok, ways_ok, gran_ok, cfg_legal;
  logic [2:0] gran_eff;

  always_comb begin
    size_ok   = size_is_legal(64'(cfg_size), SIZE_LSB);
    ways_ok   = ways_is_legal(cfg_ways, NTGT);
    gran_ok   = !cfg_gran_set || (int'(cfg_gran) <= GRAN_MAX);
    cfg_legal = size_ok && ways_ok && gran_ok;
    gran_eff  = cfg_gran_set ? cfg_gran : 3'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      rej    <= 1'b0;
      base_q <= '0;
      size_q <= '0;
      wlog_q <= '0;
      gran_q <= '0;
    end else begin
      rej <= 1'b0;
      if (cfg_we) begin
        if (cfg_legal) begin
          active <= 1'b1;
          base_q <= cfg_base;
          size_q <= cfg_size;
          wlog_q <= ways_to_log2(cfg_ways);
          gran_q <= gran_eff;
        end else begin
          active <= 1'b0;
          rej    <= 1'b1;
        end
      end
    end
  end

  AST_CFG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_legal) |=> (!active && rej)); // R1
  AST_CFG_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_legal) |=> (active && !rej)); // R1
  AST_GRAN_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_legal && !cfg_gran_set) |=> (gran_q == 3'd0)); // R2

endmodule

// File: rtl/iwr_decode.sv
module iwr_decode
  import iwr_pkg::*;
#(
  parameter int ADDR_W = 52,
  parameter int NTGT   = 8,
  localparam int TGT_W = $clog2(NTGT)
) (
  input  logic              active,
  input  logic [ADDR_W-1:0] base_q,
  input  logic [ADDR_W-1:0] size_q,
  input  logic [2:0]        wlog_q,
  input  logic [2:0]        gran_q,
  input  logic [NTGT-1:0]   present,
  input  logic [ADDR_W-1:0] off,
  input  logic [2:0]        len,
  output logic [ADDR_W-1:0] hpa,
  output logic [TGT_W-1:0]  tgt,
  output logic              in_range,
  output logic              route
);

  logic [ADDR_W:0] end_ex;

  always_comb begin
    hpa      = base_q + off;
    tgt      = TGT_W'(slice_target(64'(hpa), gran_q, wlog_q));
    end_ex   = {1'b0, off} + (ADDR_W+1)'(len) + (ADDR_W+1)'(1);
    in_range = end_ex <= {1'b0, size_q};
    route    = active && in_range && present[tgt];
  end

endmodule

// File: rtl/iwr_xact.sv
module iwr_xact
  import iwr_pkg::*;
#(
  parameter int ADDR_W = 52,
  parameter int NTGT   = 8,
  parameter int DATA_W = 64,
  localparam int TGT_W = $clog2(NTGT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [2:0]             req_len,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [ADDR_W-1:0]      hpa,
  input  logic [TGT_W-1:0]       tgt,
  input  logic                   route,
  output logic                   rsp_valid,
  output logic                   rsp_err,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [NTGT-1:0]        dn_valid,
  input  logic [NTGT-1:0]        dn_ready,
  output logic                   dn_we,
  output logic [ADDR_W-1:0]      dn_addr,
  output logic [2:0]             dn_len,
  output logic [DATA_W-1:0]      dn_wdata,
  input  logic [NTGT-1:0]        dn_rsp_valid,
  input  logic [NTGT-1:0]        dn_rsp_err,
  input  logic [NTGT*DATA_W-1:0] dn_rsp_rdata
);

  xact_st_t         st;
  logic [TGT_W-1:0] tgt_q;
  logic             req_fire, drop_fire, sel_ready, sel_rsp;

  always_comb begin
    req_ready = (st == XS_IDLE);
    req_fire  = req_valid && req_ready;
    drop_fire = req_fire && !route;
    sel_ready = dn_ready[tgt_q];
    sel_rsp   = dn_rsp_valid[tgt_q];
    rsp_valid = (st == XS_RESP);
    dn_valid  = (st == XS_ISSUE) ? (NTGT'(1) << tgt_q) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= XS_IDLE;
      tgt_q     <= '0;
      dn_we     <= 1'b0;
      dn_addr   <= '0;
      dn_len    <= '0;
      dn_wdata  <= '0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      unique case (st)
        XS_IDLE: if (req_fire) begin
          tgt_q    <= tgt;
          dn_we    <= req_we;
          dn_addr  <= hpa;
          dn_len   <= req_len;
          dn_wdata <= req_wdata;
          if (route) begin
            st <= XS_ISSUE;
          end else begin
            rsp_err   <= !req_we;
            rsp_rdata <= '0;
            st        <= XS_RESP;
          end
        end
        XS_ISSUE: if (sel_ready) st <= XS_WAIT;
        XS_WAIT: if (sel_rsp) begin
          rsp_err   <= dn_rsp_err[tgt_q];
          rsp_rdata <= dn_rsp_rdata[tgt_q*DATA_W +: DATA_W];
          st        <= XS_RESP;
        end
        XS_RESP: st <= XS_IDLE;
        default: st <= XS_IDLE;
      endcase
    end
  end

  AST_DN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_valid)); // R5
  AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dn_valid & ~dn_ready)) |=> (dn_valid == $past(dn_valid))); // R5
  AST_DROP_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_fire && !req_we) |=> (rsp_valid && rsp_err && rsp_rdata == '0 && dn_valid == '0)); // R6
  AST_DROP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_fire && req_we) |=> (rsp_valid && !rsp_err && dn_valid == '0)); // R7
  AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready); // R10
  AST_FWD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && route) |=> (dn_we == $past(req_we) && dn_len == $past(req_len)
                             && dn_wdata == $past(req_wdata))); // R11

endmodule

// File: rtl/ilv_window_router.sv
module ilv_window_router
  import iwr_pkg::*;
#(
  parameter int ADDR_W   = 52,
  parameter int NTGT     = 8,
  parameter int DATA_W   = 64,
  parameter int SIZE_LSB = 28,
  parameter int GRAN_MAX = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [ADDR_W-1:0]      cfg_base,
  input  logic [ADDR_W-1:0]      cfg_size,
  input  logic [3:0]             cfg_ways,
  input  logic                   cfg_gran_set,
  input  logic [2:0]             cfg_gran,
  output logic                   win_active,
  output logic                   cfg_rej,
  input  logic [NTGT-1:0]        tgt_present,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ADDR_W-1:0]      req_off,
  input  logic [2:0]             req_len,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic                   rsp_err,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [NTGT-1:0]        dn_valid,
  input  logic [NTGT-1:0]        dn_ready,
  output logic                   dn_we,
  output logic [ADDR_W-1:0]      dn_addr,
  output logic [2:0]             dn_len,
  output logic [DATA_W-1:0]      dn_wdata,
  input  logic [NTGT-1:0]        dn_rsp_valid,
  input  logic [NTGT-1:0]        dn_rsp_err,
  input  logic [NTGT*DATA_W-1:0] dn_rsp_rdata
);

  localparam int TGT_W = $clog2(NTGT);

  logic [ADDR_W-1:0] base_q, size_q, hpa;
  logic [2:0]        wlog_q, gran_q;
  logic [TGT_W-1:0]  tgt;
  logic              in_range, route;

  iwr_cfg #(
    .ADDR_W(ADDR_W), .NTGT(NTGT), .SIZE_LSB(SIZE_LSB), .GRAN_MAX(GRAN_MAX)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .cfg_ways(cfg_ways), .cfg_gran_set(cfg_gran_set),
    .cfg_gran(cfg_gran), .active(win_active), .rej(cfg_rej),
    .base_q(base_q), .size_q(size_q), .wlog_q(wlog_q), .gran_q(gran_q)
  );

  iwr_decode #(.ADDR_W(ADDR_W), .NTGT(NTGT)) u_dec (
    .active(win_active), .base_q(base_q), .size_q(size_q), .wlog_q(wlog_q),
    .gran_q(gran_q), .present(tgt_present), .off(req_off), .len(req_len),
    .hpa(hpa), .tgt(tgt), .in_range(in_range), .route(route)
  );

  iwr_xact #(.ADDR_W(ADDR_W), .NTGT(NTGT), .DATA_W(DATA_W)) u_xact (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_len(req_len), .req_wdata(req_wdata), .hpa(hpa),
    .tgt(tgt), .route(route), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_we(dn_we), .dn_addr(dn_addr), .dn_len(dn_len), .dn_wdata(dn_wdata),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_err(dn_rsp_err),
    .dn_rsp_rdata(dn_rsp_rdata)
  );

  AST_HPA_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && route) |=>
      (dn_addr == ADDR_W'($past(base_q) + $past(req_off)))); // R3
  AST_RANGE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !in_range) |=> (rsp_valid && dn_valid == '0)); // R8

endmodule

// File: tb/tb_ilv_window_router.sv
`timescale 1ns/1ps
module tb_ilv_window_router;
  localparam int AW = 52;
  localparam int NT = 8;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic cfg_we = 0, cfg_gran_set = 0;
  logic [AW-1:0] cfg_base = '0, cfg_size = '0;
  logic [3:0] cfg_ways = '0;
  logic [2:0] cfg_gran = '0;
  logic win_active, cfg_rej;
  logic [NT-1:0] tgt_present = '1;
  logic req_valid = 0, req_we = 0;
  logic [AW-1:0] req_off = '0;
  logic [2:0] req_len = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic [NT-1:0] dn_valid;
  logic [NT-1:0] dn_ready = '1;
  logic dn_we;
  logic [AW-1:0] dn_addr;
  logic [2:0] dn_len;
  logic [DW-1:0] dn_wdata;
  logic [NT-1:0] dn_rsp_valid = '0, dn_rsp_err = '0;
  logic [NT*DW-1:0] dn_rsp_rdata = '0;

  ilv_window_router #(.ADDR_W(AW), .NTGT(NT), .DATA_W(DW)) dut (.*);

  int vectors = 0, errors = 0;
  int dn_hits = 0;
  int last_idx = 0;
  logic [AW-1:0] last_addr;
  logic last_we;
  logic [2:0] last_len;
  logic [DW-1:0] last_wdata;
  logic model_err = 1'b0;
  logic pend = 1'b0;
  int pend_idx = 0;
  logic [AW-1:0] pend_addr;

  // model of the downstream ports: answer one cycle after the handshake
  always @(negedge clk) begin
    dn_rsp_valid <= '0;
    dn_rsp_err   <= '0;
    pend         <= 1'b0;
    if (pend) begin
      dn_rsp_valid[pend_idx] <= 1'b1;
      dn_rsp_err[pend_idx]   <= model_err;
      dn_rsp_rdata[pend_idx*DW +: DW] <= {4'hC, 1'b0, 3'(pend_idx), 4'h0, pend_addr};
    end
    if (|(dn_valid & dn_ready)) begin
      for (int i = 0; i < NT; i++) if (dn_valid[i]) begin
        pend_idx <= i;
        last_idx = i;
      end
      pend       <= 1'b1;
      pend_addr  <= dn_addr;
      last_addr  = dn_addr;
      last_we    = dn_we;
      last_len   = dn_len;
      last_wdata = dn_wdata;
      dn_hits++;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // window state kept by the bench
  logic [AW-1:0] m_base, m_size;
  int m_ways, m_gran;
  logic m_active = 0;

  function automatic int exp_target(input logic [AW-1:0] hpa);
    longint unsigned unit;
    unit = 64'd256 * (64'd1 << m_gran);
    return int'((64'(hpa) / unit) % longint'(m_ways));
  endfunction

  task automatic do_cfg(input logic [AW-1:0] b, input logic [AW-1:0] s, input int w,
                        input logic gs, input int g, input logic exp_ok, input string tag);
    @(negedge clk);
    cfg_we = 1; cfg_base = b; cfg_size = s; cfg_ways = 4'(w);
    cfg_gran_set = gs; cfg_gran = 3'(g);
    @(negedge clk);
    cfg_we = 0;
    check(win_active == exp_ok && cfg_rej == !exp_ok, tag,
          {62'd0, win_active, cfg_rej}, {62'd0, exp_ok, !exp_ok});
    @(negedge clk);
    check(cfg_rej == 1'b0, tag, 64'(cfg_rej), 64'd0);
    m_active = exp_ok;
    if (exp_ok) begin
      m_base = b; m_size = s; m_ways = w; m_gran = gs ? g : 0;
    end
  endtask

  // issue one request from idle; returns response and wait count
  task automatic do_req(input logic [AW-1:0] off, input logic we, input logic [2:0] len,
                        input logic [DW-1:0] wd, output logic e, output logic [DW-1:0] rd,
                        output int waits);
    @(negedge clk);
    req_valid = 1; req_we = we; req_off = off; req_len = len; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    waits = 0;
    while (!rsp_valid && waits < 30) begin
      @(negedge clk);
      waits++;
    end
    e = rsp_err; rd = rsp_rdata;
  endtask

  // routed request with full expectation
  task automatic routed(input logic [AW-1:0] off, input logic we, input logic [2:0] len,
                        input logic [DW-1:0] wd, input string tag);
    logic e; logic [DW-1:0] rd; int waits; int h0; int ti;
    logic [AW-1:0] hpa;
    hpa = m_base + off;
    ti = exp_target(hpa);
    h0 = dn_hits;
    do_req(off, we, len, wd, e, rd, waits);
    check(dn_hits == h0 + 1 && last_idx == ti, {tag, " R4 target"}, 64'(last_idx), 64'(ti));
    check(last_addr == hpa, {tag, " R3 hpa"}, 64'(last_addr), 64'(hpa));
    check(last_we == we && last_len == len && (!we || last_wdata == wd), {tag, " R11 fields"},
          {last_wdata[59:0], last_len, last_we}, {wd[59:0], len, we});
    check(e == model_err && rd == {4'hC, 1'b0, 3'(ti), 4'h0, hpa}, {tag, " R9 response"},
          rd, {4'hC, 1'b0, 3'(ti), 4'h0, hpa});
  endtask

  // unroutable request: response one cycle after acceptance, nothing downstream
  task automatic dropped(input logic [AW-1:0] off, input logic we, input logic [2:0] len, input string tag);
    logic e; logic [DW-1:0] rd; int waits; int h0;
    h0 = dn_hits;
    do_req(off, we, len, 64'hDEAD_BEEF_0000_1111, e, rd, waits);
    check(waits == 0 && dn_hits == h0, {tag, " timing/no-forward"}, 64'(waits), 64'd0);
    if (we) check(e == 1'b0, {tag, " R7 write ok"}, 64'(e), 64'd0);
    else    check(e == 1'b1 && rd == '0, {tag, " R6 poison"}, {63'(rd), e}, 64'd1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !rsp_valid && dn_valid == '0 && !win_active && !cfg_rej, "reset R10",
          {59'd0, req_ready, rsp_valid, |dn_valid, win_active, cfg_rej}, 64'h10);

    // R8: no active window
    dropped(52'h100, 1'b0, 3'd7, "R8 no window read");
    dropped(52'h100, 1'b1, 3'd7, "R8 no window write");

    // R1 rejections
    do_cfg(52'h0, 52'h0800_0000, 4, 1, 0, 1'b0, "R1 size 128MiB");
    do_cfg(52'h0, 52'h0, 4, 1, 0, 1'b0, "R1 size zero");
    do_cfg(52'h0, 52'h4000_0000, 3, 1, 0, 1'b0, "R1 ways 3");
    do_cfg(52'h0, 52'h4000_0000, 0, 1, 0, 1'b0, "R1 ways 0");
    do_cfg(52'h0, 52'h4000_0000, 4, 1, 7, 1'b0, "R1 gran 7");

    // legal: 4 ways, 1 KiB granularity, odd base
    do_cfg(52'h0_0123_4560_0100, 52'h4000_0000, 4, 1, 2, 1'b1, "R1 accept 4w");
    for (int k = 0; k < 40; k++) begin
      logic [63:0] r;
      r = {$urandom, $urandom} % 64'(m_size - 8);
      routed(AW'(r), 1'($urandom), 3'($urandom), {$urandom, $urandom}, "R5 random 4w");
    end
    // R1: a rejected strobe clears a live window
    do_cfg(52'h0, 52'h1000_0001, 2, 0, 0, 1'b0, "R1 reject clears");
    dropped(52'h0, 1'b0, 3'd0, "R8 after reject");

    // R2: no granularity supplied, code field ignored; 8 ways
    do_cfg(52'h0_0000_1000_0000, 52'h1000_0000, 8, 0, 7, 1'b1, "R2 accept default gran");
    for (int k = 0; k < 8; k++) routed(AW'(k * 256 + 17), 1'b0, 3'd3, 64'd0, "R2 256B stride");
    for (int k = 0; k < 30; k++) begin
      logic [63:0] r;
      r = {$urandom, $urandom} % 64'(m_size - 8);
      routed(AW'(r), 1'($urandom), 3'($urandom), {$urandom, $urandom}, "R4 random 8w");
    end

    // range boundary
    routed(m_size - 8, 1'b0, 3'd7, 64'd0, "R8 last bytes");
    dropped(m_size - 4, 1'b0, 3'd7, "R8 crosses end read");
    dropped(m_size - 4, 1'b1, 3'd7, "R8 crosses end write");
    dropped(m_size, 1'b1, 3'd0, "R7 past end write");

    // absent target: offset 3*256 selects port 3
    tgt_present = 8'b1111_0111;
    dropped(52'd768, 1'b0, 3'd1, "R8 absent port read");
    dropped(52'd768, 1'b1, 3'd1, "R7 absent port write");
    routed(52'd1024, 1'b0, 3'd1, 64'd0, "R8 neighbour present");
    tgt_present = '1;

    // R9: error reported by the port is passed up
    model_err = 1'b1;
    routed(52'd512, 1'b0, 3'd7, 64'd0, "R9 port error");
    model_err = 1'b0;

    // single way, max granularity, top of 1 TiB window
    do_cfg(52'h0_FF00_0000_0000, 52'h100_0000_0000, 1, 1, 6, 1'b1, "R1 accept 1w");
    for (int k = 0; k < 6; k++) begin
      logic [63:0] r;
      r = {$urandom, $urandom} % 64'(m_size - 8);
      routed(AW'(r), 1'b1, 3'($urandom), {$urandom, $urandom}, "R4 single way");
    end

    // R10: request held while busy is taken only after the response
    begin
      logic e; logic [DW-1:0] rd; int waits;
      dn_ready = '0;
      @(negedge clk);
      req_valid = 1; req_we = 0; req_off = 52'h40; req_len = 3'd0;
      @(negedge clk);
      check(!req_ready && dn_valid != '0, "R10 busy", 64'(req_ready), 64'd0);
      req_valid = 0;
      repeat (3) @(negedge clk);
      check(dn_valid != '0 && dn_hits >= 0, "R5 held without ready", 64'(dn_valid), 64'd1);
      dn_ready = '1;
      waits = 0;
      while (!rsp_valid && waits < 30) begin @(negedge clk); waits++; end
      e = rsp_err; rd = rsp_rdata;
      check(rsp_valid && !e, "R10 completes", 64'(e), 64'd0);
      @(negedge clk);
      check(req_ready, "R10 idle again", 64'(req_ready), 64'd1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule